// File: doc/BRIEF.md
# Memory Self-Refresh Sequencer

This block controls self-refresh for a DDR2 memory controller. Software raises a request level. The block then closes every bank with a precharge-all, waits the row-precharge time and issues the self-refresh command in the same cycle that clock enable (CKE) falls. Software polls a status output to learn when the memory is in self-refresh. While the sequencer is busy it owns the command bus. In its idle state the normal command path has the bus.

Any access to the memory address space wakes the memory, but only after a minimum residency time has passed. Raising CKE switches the memory's DLL back on, so the access is stalled. A write or other non-read access waits a programmable no-read exit delay. A read waits a fixed, longer delay so that the DLL can re-lock. After the delay the access is granted and the bus goes back to the normal path.

The block never gates the memory clock itself. Software may freeze that clock with a separate disable level. An access that arrives while the disable level is high gets a one-cycle bus error, and the memory stays in self-refresh.

The states are IDLE, PRECHARGE, ENTER, IN_SR_MIN, IN_SR, EXIT_WAIT and ERROR_RESP. The transitions are:
- IDLE to PRECHARGE when a request is seen.
- PRECHARGE to ENTER after one cycle.
- ENTER to IN_SR_MIN when the precharge wait expires.
- IN_SR_MIN to IN_SR when the residency wait expires.
- IN_SR to EXIT_WAIT on an access while the clock is running.
- IN_SR to ERROR_RESP on an access while the clock is frozen.
- ERROR_RESP back to IN_SR after one cycle.
- EXIT_WAIT to IDLE when the exit wait expires.

Top module: `srf_sequencer`

## Requirements
- R1: After reset the outputs take these values: cke=1, cmd={cs_n,ras_n,cas_n,we_n}=4'b0111 (NOP), a10=0, sr_active=0, acc_ready=1, bus_err=0, busy=0.
- R2: A high sr_req seen in IDLE produces a precharge-all in the next cycle. That cycle has cmd=4'b0010, a10=1, cke=1 and busy=1.
- R3: The self-refresh command (cmd=4'b0001, cke=0) comes exactly cfg_trp cycles after the precharge-all, with a cfg_trp of 0 treated as 1. The cycles in between carry NOP with cke=1. CKE falls in the same cycle as the self-refresh command.
- R4: sr_active rises in the cycle after the self-refresh command. It stays high only while cke is low.
- R5: An access is not honoured during the max(cfg_tras,1) cycles that follow the self-refresh command. An access that has been pending since that command sees cke rise exactly cfg_tras+2 cycles after it.
- R6: An access seen in IN_SR with clk_off=0 raises cke in the next cycle. sr_active clears in that same cycle.
- R7: For a non-read access, acc_ready rises exactly max(cfg_txsnr,1) cycles after cke rises.
- R8: For a read access (acc_is_read=1), acc_ready rises exactly RD_EXIT cycles after cke rises. RD_EXIT defaults to 200.
- R9: acc_ready is low and busy is high in every cycle outside IDLE.
- R10: An access seen in IN_SR with clk_off=1 produces bus_err for exactly one cycle, in the next cycle. cke stays low, sr_active stays high and no command is issued. A later access with clk_off=0 exits normally.
- R11: A request raised during EXIT_WAIT has no effect until IDLE. In that case IDLE lasts one cycle and the precharge-all follows in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sr_req | input | 1 | Software self-refresh request level |
| clk_off | input | 1 | Software memory-clock freeze level |
| acc_valid | input | 1 | Access to memory space pending; held until acc_ready or bus_err |
| acc_is_read | input | 1 | Pending access is a read |
| cfg_trp | input | CNT_W | Precharge-to-command cycles |
| cfg_tras | input | CNT_W | Minimum self-refresh residency cycles |
| cfg_txsnr | input | CNT_W | No-read exit delay cycles |
| cke | output | 1 | Memory clock enable |
| cmd | output | 4 | Command {cs_n,ras_n,cas_n,we_n} |
| a10 | output | 1 | All-banks select for precharge |
| sr_active | output | 1 | Memory is in self-refresh |
| acc_ready | output | 1 | Access may proceed on the normal path |
| bus_err | output | 1 | One-cycle error for an access while the clock is frozen |
| busy | output | 1 | Sequencer owns the command bus |

## Verification
The bench uses two different precharge waits, and a zero precharge wait must behave as one. A counter that is off by one would move the self-refresh command by one cycle.

It holds an access pending from the moment of entry. A design that skipped the residency wait would raise CKE too early. It compares a read exit against a write exit. A design that used the no-read delay for reads would grant the read about 190 cycles early.

It issues an access while the clock is frozen. A faulty design would wake the memory or hold the error for more than one cycle. It also raises a new request in the middle of an exit. A design without the hold-off would precharge before the stalled access is granted.

// File: rtl/srf_pkg.sv
package srf_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_PRECHARGE,
        S_ENTER,
        S_IN_SR_MIN,
        S_IN_SR,
        S_EXIT_WAIT,
        S_ERROR_RESP
    } srf_state_e;

    // {cs_n, ras_n, cas_n, we_n}
    localparam logic [3:0] CMD_NOP  = 4'b0111;
    localparam logic [3:0] CMD_PRE  = 4'b0010;
    localparam logic [3:0] CMD_SREF = 4'b0001;
endpackage

// File: rtl/srf_timer.sv
module srf_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         done
);
    logic [W-1:0] count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (load) begin
            count_q <= val;
        end else if (count_q != '0) begin
            count_q <= count_q - 1'b1;
        end
    end

    assign done = (count_q == '0);
endmodule

// File: rtl/srf_outdec.sv
module srf_outdec
    import srf_pkg::*;
(
    input  srf_state_e  state,
    input  logic        tmr_done,
    output logic        cke,
    output logic [3:0]  cmd,
    output logic        a10,
    output logic        sr_active,
    output logic        acc_ready,
    output logic        bus_err,
    output logic        busy
);
    always_comb begin
        cke       = 1'b1;
        cmd       = CMD_NOP;
        a10       = 1'b0;
        sr_active = 1'b0;
        acc_ready = 1'b0;
        bus_err   = 1'b0;
        busy      = 1'b1;
        unique case (state)
            S_IDLE: begin
                acc_ready = 1'b1;
                busy      = 1'b0;
            end
            S_PRECHARGE: begin
                cmd = CMD_PRE;
                a10 = 1'b1;
            end
            S_ENTER: begin
                cke = !tmr_done;
                cmd = tmr_done ? CMD_SREF : CMD_NOP;
            end
            S_IN_SR_MIN, S_IN_SR: begin
                cke       = 1'b0;
                sr_active = 1'b1;
            end
            S_ERROR_RESP: begin
                cke       = 1'b0;
                sr_active = 1'b1;
                bus_err   = 1'b1;
            end
            S_EXIT_WAIT: begin
                cke = 1'b1;
            end
            default: begin
                cke = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/srf_sequencer.sv
module srf_sequencer
    import srf_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int RD_EXIT = 200
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sr_req,
    input  logic             clk_off,
    input  logic             acc_valid,
    input  logic             acc_is_read,
    input  logic [CNT_W-1:0] cfg_trp,
    input  logic [CNT_W-1:0] cfg_tras,
    input  logic [CNT_W-1:0] cfg_txsnr,
    output logic             cke,
    output logic [3:0]       cmd,
    output logic             a10,
    output logic             sr_active,
    output logic             acc_ready,
    output logic             bus_err,
    output logic             busy
);
    // Timer loads hold the wait length minus one, because a timer load
    // also consumes the first cycle of the wait.
    localparam logic [CNT_W-1:0] RD_LD = CNT_W'(RD_EXIT - 1);

    function automatic logic [CNT_W-1:0] len_to_ld(input logic [CNT_W-1:0] v);
        return (v == '0) ? '0 : v - 1'b1;
    endfunction

    srf_state_e       state_q, state_d;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_done;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            S_IDLE:
                if (sr_req) state_d = S_PRECHARGE;
            S_PRECHARGE: begin
                tmr_load = 1'b1;
                tmr_val  = len_to_ld(cfg_trp);
                state_d  = S_ENTER;
            end
            S_ENTER:
                if (tmr_done) begin
                    tmr_load = 1'b1;
                    tmr_val  = len_to_ld(cfg_tras);
                    state_d  = S_IN_SR_MIN;
                end
            S_IN_SR_MIN:
                if (tmr_done) state_d = S_IN_SR;
            S_IN_SR:
                if (acc_valid) begin
                    if (clk_off) begin
                        state_d = S_ERROR_RESP;
                    end else begin
                        tmr_load = 1'b1;
                        tmr_val  = acc_is_read ? RD_LD : len_to_ld(cfg_txsnr);
                        state_d  = S_EXIT_WAIT;
                    end
                end
            S_ERROR_RESP:
                state_d = S_IN_SR;
            S_EXIT_WAIT:
                if (tmr_done) state_d = S_IDLE;
            default:
                state_d = S_IDLE;
        endcase
    end

    srf_timer #(.W(CNT_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .val   (tmr_val),
        .done  (tmr_done)
    );

    srf_outdec u_outdec (
        .state     (state_q),
        .tmr_done  (tmr_done),
        .cke       (cke),
        .cmd       (cmd),
        .a10       (a10),
        .sr_active (sr_active),
        .acc_ready (acc_ready),
        .bus_err   (bus_err),
        .busy      (busy)
    );
endmodule

// File: rtl/srf_sequencer_chk.sv
module srf_sequencer_chk
    import srf_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       cke,
    input logic [3:0] cmd,
    input logic       a10,
    input logic       sr_active,
    input logic       acc_ready,
    input logic       bus_err,
    input logic       busy
);
    AST_PRE_ALL_BANKS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_PRE) |-> (cke && a10)); // R2
    AST_SREF_WITH_CKE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_SREF) |-> (!cke && $past(cke))); // R3
    AST_STATUS_ONLY_CKE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        sr_active |-> !cke); // R4
    AST_CKE_RISE_CLEARS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke) |-> (!sr_active && $past(sr_active))); // R6
    AST_NO_READY_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !acc_ready); // R9
    AST_ERR_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |=> (!bus_err && !cke && sr_active)); // R10
    AST_NO_PRE_AFTER_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && !$past(cke)) |=> (cmd != CMD_PRE)); // R11
endmodule

bind srf_sequencer srf_sequencer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cke       (cke),
    .cmd       (cmd),
    .a10       (a10),
    .sr_active (sr_active),
    .acc_ready (acc_ready),
    .bus_err   (bus_err),
    .busy      (busy)
);

// File: tb/srf_sequencer_tb.sv
module srf_sequencer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 8;
    localparam int RD = 200;

    // Observed pattern: {cke, cmd[3:0], a10, sr_active, acc_ready, bus_err, busy}
    localparam logic [9:0] P_IDLE = {1'b1, 4'b0111, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0};
    localparam logic [9:0] P_PRE  = {1'b1, 4'b0010, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1};
    localparam logic [9:0] P_ENTW = {1'b1, 4'b0111, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1};
    localparam logic [9:0] P_SREF = {1'b0, 4'b0001, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1};
    localparam logic [9:0] P_SR   = {1'b0, 4'b0111, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1};
    localparam logic [9:0] P_ERR  = {1'b0, 4'b0111, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1};
    localparam logic [9:0] P_EXIT = {1'b1, 4'b0111, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sr_req = 1'b0, clk_off = 1'b0, acc_valid = 1'b0, acc_is_read = 1'b0;
    logic [CW-1:0] cfg_trp = '0, cfg_tras = '0, cfg_txsnr = '0;
    logic cke, a10, sr_active, acc_ready, bus_err, busy;
    logic [3:0] cmd;

    int cyc = 0;
    int n_tests = 0;
    int n_fail = 0;
    bit done_flag = 1'b0;

    int    q_cyc[$];
    logic [9:0] q_pat[$];
    string q_tag[$];

    srf_sequencer #(.CNT_W(CW), .RD_EXIT(RD)) u_dut (
        .clk(clk), .rst_n(rst_n), .sr_req(sr_req), .clk_off(clk_off),
        .acc_valid(acc_valid), .acc_is_read(acc_is_read),
        .cfg_trp(cfg_trp), .cfg_tras(cfg_tras), .cfg_txsnr(cfg_txsnr),
        .cke(cke), .cmd(cmd), .a10(a10), .sr_active(sr_active),
        .acc_ready(acc_ready), .bus_err(bus_err), .busy(busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: pop expected items whose cycle has come and compare.
    always @(negedge clk) begin
        while (q_cyc.size() > 0 && q_cyc[0] <= cyc) begin
            int         c;
            logic [9:0] p;
            logic [9:0] got;
            string      t;
            c   = q_cyc.pop_front();
            p   = q_pat.pop_front();
            t   = q_tag.pop_front();
            got = {cke, cmd, a10, sr_active, acc_ready, bus_err, busy};
            n_tests++;
            if (c != cyc || got !== p) begin
                n_fail++;
                $display("FAIL %s cycle %0d: actual %b expected %b (due %0d)", t, cyc, got, p, c);
            end
        end
    end

    task automatic push(input int c, input logic [9:0] p, input string t);
        q_cyc.push_back(c);
        q_pat.push_back(p);
        q_tag.push_back(t);
    endtask

    task automatic go(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    // Driver: raise the request and predict the entry sequence (R2 R3 R4).
    task automatic do_entry(input int trp, input int tras, output int ts);
        int c;
        c = cyc;
        sr_req = 1'b1;
        push(c + 1, P_PRE, "R2");
        for (int k = 1; k < trp; k++) push(c + 1 + k, P_ENTW, "R3");
        ts = c + 1 + trp;
        push(ts, P_SREF, "R3");
        push(ts + 1, P_SR, "R4");
        if (tras > 1) push(ts + tras, P_SR, "R5");
        go(c + 1);
        sr_req = 1'b0;
    endtask

    // Driver: access while in IN_SR, predict the stall length (R6 R7 R8).
    task automatic do_exit(input bit rd, input int n, input string tag);
        int c;
        c = cyc;
        acc_valid = 1'b1;
        acc_is_read = rd;
        push(c + 1, P_EXIT, "R6");
        if (n > 1) push(c + n, P_EXIT, tag);
        push(c + n + 1, P_IDLE, tag);
        go(c + n + 1);
        acc_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1'b1;
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int ts;
        int c;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        push(cyc + 1, P_IDLE, "R1");
        go(cyc + 2);

        // A: write exit, tRP=3, tRAS=5, tXSNR=4
        cfg_trp = 8'd3; cfg_tras = 8'd5; cfg_txsnr = 8'd4;
        do_entry(3, 5, ts);
        go(ts + 5 + 1);
        push(cyc, P_SR, "R5");
        do_exit(1'b0, 4, "R7");
        go(cyc + 2);

        // B: read exit with access pending from the self-refresh command
        cfg_trp = 8'd1; cfg_tras = 8'd2;
        do_entry(1, 2, ts);
        go(ts);
        acc_valid = 1'b1; acc_is_read = 1'b1;
        push(ts + 3, P_SR, "R5");
        push(ts + 4, P_EXIT, "R5");
        push(ts + 4 + RD - 1, P_EXIT, "R8");
        push(ts + 4 + RD, P_IDLE, "R8");
        go(ts + 4 + RD);
        acc_valid = 1'b0; acc_is_read = 1'b0;
        go(cyc + 2);

        // C: access while clock frozen, then normal exit
        cfg_trp = 8'd2; cfg_tras = 8'd3; cfg_txsnr = 8'd2;
        do_entry(2, 3, ts);
        go(ts + 3 + 1);
        c = cyc;
        clk_off = 1'b1; acc_valid = 1'b1;
        push(c + 1, P_ERR, "R10");
        push(c + 2, P_SR, "R10");
        push(c + 4, P_SR, "R10");
        go(c + 1);
        acc_valid = 1'b0;
        go(c + 4);
        clk_off = 1'b0;
        do_exit(1'b0, 2, "R10");
        go(cyc + 2);

        // D: request during exit is held off; zero tRP acts as one
        cfg_txsnr = 8'd3; cfg_tras = 8'd1;
        do_entry(2, 1, ts);
        go(ts + 2);
        c = cyc;
        acc_valid = 1'b1;
        cfg_trp = 8'd0;
        push(c + 1, P_EXIT, "R6");
        go(c + 1);
        sr_req = 1'b1;
        push(c + 2, P_EXIT, "R11");
        push(c + 3, P_EXIT, "R11");
        push(c + 4, P_IDLE, "R11");
        push(c + 5, P_PRE, "R11");
        push(c + 6, P_SREF, "R3");
        push(c + 7, P_SR, "R4");
        go(c + 4);
        acc_valid = 1'b0;
        go(c + 5);
        sr_req = 1'b0;
        go(c + 8);
        do_exit(1'b0, 3, "R7");
        go(cyc + 2);

        while (q_cyc.size() > 0) @(negedge clk);
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule